// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit sits between requesters and a single-port, synchronous word memory. It takes one request at a time on a valid/ready channel. Each request carries an opcode, an address, an operand and a compare value. The unit runs the memory read and the memory write of that request back to back and keeps ownership of the memory port for the whole sequence, so no other access can fall between them. It then presents a result on a valid/ready response channel and accepts nothing new until that result has been taken.

The supported operations are:
- plain load and plain store;
- test-and-set;
- swap;
- fetch-and-add and fetch-and-subtract;
- a fetch-logic operation whose sub-field picks AND, OR or XOR;
- compare-and-swap.

Every read-modify-write operation reports the value the word held before the update. Compare-and-swap instead reports whether its store took place. A compare-and-swap whose comparison fails never drives a write cycle. A plain store is one write cycle with no read.

The memory returns read data in the cycle after an enabled read.

Top module: `amo_unit`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and memEn is 0.
- R2: Load (opcode 0) returns the addressed word, performs one read and performs no write.
- R3: Store (opcode 1) writes the operand in exactly one write cycle with no read cycle, and returns 0.
- R4: Test-and-set (opcode 2) writes 1 to the word and returns the value held before the write.
- R5: Swap (opcode 3) writes the operand to the word and returns the old value.
- R6: Fetch-add (opcode 4) and fetch-sub (opcode 5) store old+operand and old-operand respectively, wrapping modulo 2^DATA_W, and return the old value.
- R7: Fetch-logic (opcode 6) stores old AND operand when reqLogicSel is 0, old OR operand when it is 1, and old XOR operand when it is 2 or 3, and returns the old value.
- R8: Compare-and-swap (opcode 7) whose old value equals reqCompare stores reqOperand and returns 1.
- R9: Compare-and-swap whose old value differs from reqCompare performs no memory write cycle, leaves the word unchanged and returns 0.
- R10: From the cycle after a request is accepted until its response is accepted, reqReady is 0. While rspValid is high and rspReady is low, rspValid stays high and rspData stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqOp | input | 3 | Operation code |
| reqLogicSel | input | 2 | Logic function for fetch-logic |
| reqAddr | input | ADDR_W | Word address |
| reqOperand | input | DATA_W | Operand, store value or new value |
| reqCompare | input | DATA_W | Compare value for compare-and-swap |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspData | output | DATA_W | Old value, success flag or zero |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write when enabled |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid one cycle after a read |

## Verification
Directed cases separate the arithmetic edges: a fetch-add that wraps past all ones, a fetch-sub below zero, and every fetch-logic selector value on the same operands, so a swapped function is seen. They also cover compare-and-swap against a matching and against a mismatching compare value, which separates the write and no-write paths through both the returned flag and the count of write cycles.

Random sequences then mix all opcodes over a small address range, with random response stalls. The old values that each operation returns expose any lost or misplaced write, and the stalls show up any change to a pending response. A closing sweep of loads compares every touched word with the bench's own model.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_TAS    = 3'd2,
    OP_SWAP   = 3'd3,
    OP_FADD   = 3'd4,
    OP_FSUB   = 3'd5,
    OP_FLOGIC = 3'd6,
    OP_CAS    = 3'd7
  } amoOp_e;

  typedef struct packed {
    logic latchReq;
    logic memRead;
    logic captureOld;
    logic memWrite;
    logic writeDirect;
  } amoStrobe_t;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amoOp_e            op,
  input  logic [1:0]        logicSel,
  input  logic [DATA_W-1:0] oldVal,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] newVal
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] logicRes;

  always_comb begin
    unique case (logicSel)
      2'd0:    logicRes = oldVal & operand;
      2'd1:    logicRes = oldVal | operand;
      default: logicRes = oldVal ^ operand;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_TAS:    newVal = ONE;
      OP_FADD:   newVal = oldVal + operand;
      OP_FSUB:   newVal = oldVal - operand;
      OP_FLOGIC: newVal = logicRes;
      default:   newVal = operand;
    endcase
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       rspReady,
  input  logic       casMatch,
  output logic       reqReady,
  output logic       rspValid,
  output amoOp_e     opQ,
  output amoStrobe_t strobe
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_CAPT, S_WRITE, S_RESP} state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (reqValid) stateNext = (amoOp_e'(reqOp) == OP_STORE) ? S_WRITE : S_READ;
      S_READ:  stateNext = S_CAPT;
      S_CAPT: begin
        if (opQ == OP_LOAD)                   stateNext = S_RESP;
        else if (opQ == OP_CAS && !casMatch)  stateNext = S_RESP;
        else                                  stateNext = S_WRITE;
      end
      S_WRITE: stateNext = S_RESP;
      S_RESP:  if (rspReady) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_LOAD;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && reqValid) opQ <= amoOp_e'(reqOp);
    end
  end

  assign reqReady           = (state == S_IDLE);
  assign rspValid           = (state == S_RESP);
  assign strobe.latchReq    = (state == S_IDLE) && reqValid;
  assign strobe.memRead     = (state == S_READ);
  assign strobe.captureOld  = (state == S_CAPT);
  assign strobe.memWrite    = (state == S_WRITE);
  assign strobe.writeDirect = (opQ == OP_STORE);

  // R10: an accepted request closes the request channel
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: a pending response is not withdrawn
  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R9: failed compare goes to response without a write
  a_r9_cas_fail_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureOld && opQ == OP_CAS && !casMatch) |=> !strobe.memWrite);

  // R2: a load never writes
  a_r2_load_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureOld && opQ == OP_LOAD) |=> !strobe.memWrite);

  // R3: a store goes straight to its single write
  a_r3_store_direct: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && amoOp_e'(reqOp) == OP_STORE) |=> (strobe.memWrite && !strobe.memRead));
endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  amoStrobe_t        strobe,
  input  amoOp_e            opQ,
  input  logic [1:0]        reqLogicSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqOperand,
  input  logic [DATA_W-1:0] reqCompare,
  input  logic [DATA_W-1:0] memRdata,
  output logic              casMatch,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] operandQ, compareQ, oldQ, aluOut;
  logic [1:0]        selQ;
  logic              casOkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      operandQ <= '0;
      compareQ <= '0;
      selQ     <= '0;
      oldQ     <= '0;
      casOkQ   <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        addrQ    <= reqAddr;
        operandQ <= reqOperand;
        compareQ <= reqCompare;
        selQ     <= reqLogicSel;
      end
      if (strobe.captureOld) begin
        oldQ   <= memRdata;
        casOkQ <= casMatch;
      end
    end
  end

  amo_alu #(.DATA_W(DATA_W)) uAlu (
    .op       (opQ),
    .logicSel (selQ),
    .oldVal   (oldQ),
    .operand  (operandQ),
    .newVal   (aluOut)
  );

  assign casMatch = (memRdata == compareQ);
  assign memEn    = strobe.memRead | strobe.memWrite;
  assign memWe    = strobe.memWrite;
  assign memAddr  = addrQ;
  assign memWdata = strobe.writeDirect ? operandQ : aluOut;

  always_comb begin
    unique case (opQ)
      OP_CAS:   rspData = {{(DATA_W-1){1'b0}}, casOkQ};
      OP_STORE: rspData = '0;
      default:  rspData = oldQ;
    endcase
  end

  // R4: a test-and-set writes the value one
  a_r4_tas_writes_one: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && opQ == OP_TAS) |-> (memWdata == DATA_W'(1)));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [1:0]        reqLogicSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqOperand,
  input  logic [DATA_W-1:0] reqCompare,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  amoStrobe_t strobe;
  amoOp_e     opQ;
  logic       casMatch;

  amo_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .rspReady (rspReady),
    .casMatch (casMatch),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .opQ      (opQ),
    .strobe   (strobe)
  );

  amo_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opQ         (opQ),
    .reqLogicSel (reqLogicSel),
    .reqAddr     (reqAddr),
    .reqOperand  (reqOperand),
    .reqCompare  (reqCompare),
    .memRdata    (memRdata),
    .casMatch    (casMatch),
    .memEn       (memEn),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .rspData     (rspData)
  );

  // R10: pending response data does not change
  a_r10_rsp_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> $stable(rspData));

  // R10: the memory port is idle while the request channel is open
  a_r10_port_owned: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memEn);
endmodule

// File: tb/amo_unit_test.sv
module amo_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, rspReady = 1'b0;
  logic [2:0] reqOp = '0;
  logic [1:0] reqLogicSel = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [W-1:0] reqOperand = '0, reqCompare = '0;
  logic reqReady, rspValid, memEn, memWe;
  logic [W-1:0] rspData, memWdata;
  logic [W-1:0] memRdata;
  logic [AW-1:0] memAddr;

  logic [W-1:0] mem [0:255];
  logic [W-1:0] shadow [0:255];
  int wrCnt, rdCnt;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amo_unit #(.DATA_W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqLogicSel(reqLogicSel), .reqAddr(reqAddr),
    .reqOperand(reqOperand), .reqCompare(reqCompare), .rspValid(rspValid),
    .rspReady(rspReady), .rspData(rspData), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      memRdata <= '0;
    end else if (memEn) begin
      if (memWe) begin mem[memAddr] <= memWdata; wrCnt <= wrCnt + 1; end
      else begin memRdata <= mem[memAddr]; rdCnt <= rdCnt + 1; end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] refNew(input logic [2:0] op, input logic [1:0] sel,
      input logic [W-1:0] old, input logic [W-1:0] opd);
    case (op)
      3'd2: return 1;
      3'd4: return old + opd;
      3'd5: return old - opd;
      3'd6: return (sel == 0) ? (old & opd) : (sel == 1) ? (old | opd) : (old ^ opd);
      default: return opd;
    endcase
  endfunction

  function automatic string opTag(input logic [2:0] op, input bit casOk);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return casOk ? "R8" : "R9";
    endcase
  endfunction

  task automatic doOp(input logic [2:0] op, input logic [1:0] sel, input logic [AW-1:0] addr,
      input logic [W-1:0] opd, input logic [W-1:0] cmp);
    logic [W-1:0] old, expRsp, first;
    bit casOk, doWr, busyBad;
    int expWr, expRd;
    string tag;
    old   = shadow[addr];
    casOk = (op == 3'd7) && (old == cmp);
    doWr  = !(op == 3'd0 || (op == 3'd7 && !casOk));
    expWr = doWr ? 1 : 0;
    expRd = (op == 3'd1) ? 0 : 1;
    expRsp = (op == 3'd1) ? '0 : (op == 3'd7) ? W'(casOk) : old;
    tag = opTag(op, casOk);
    @(negedge clk);
    wrCnt = 0; rdCnt = 0;
    reqValid = 1'b1; reqOp = op; reqLogicSel = sel; reqAddr = addr;
    reqOperand = opd; reqCompare = cmp;
    @(negedge clk);
    reqValid = 1'b0;
    busyBad = 0;
    while (!rspValid) begin
      if (reqReady) busyBad = 1;
      @(negedge clk);
    end
    first = rspData;
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      if (!rspValid || rspData !== first || reqReady) busyBad = 1;
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check({tag, " response"}, first, expRsp);
    check({tag, " write cycles"}, W'(wrCnt), W'(expWr));
    check({tag, " read cycles"}, W'(rdCnt), W'(expRd));
    check("R10 busy/hold", W'(busyBad), '0);
    if (doWr) shadow[addr] = (op == 3'd1) ? opd : refNew(op, sel, old, opd);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reqReady", W'(reqReady), W'(1));
    check("R1 rspValid", W'(rspValid), '0);
    check("R1 memEn", W'(memEn), '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reqReady after release", W'(reqReady), W'(1));

    doOp(3'd1, 0, 8'd1, 32'h0000_00A5, '0);          // R3 store
    doOp(3'd0, 0, 8'd1, '0, '0);                      // R2 load
    doOp(3'd2, 0, 8'd1, 32'hDEAD, '0);                // R4 tas on nonzero
    doOp(3'd2, 0, 8'd2, '0, '0);                      // R4 tas on zero
    doOp(3'd3, 0, 8'd2, 32'h1234_5678, '0);           // R5 swap
    doOp(3'd1, 0, 8'd3, 32'hFFFF_FFFF, '0);
    doOp(3'd4, 0, 8'd3, 32'h1, '0);                   // R6 add wraps
    doOp(3'd5, 0, 8'd3, 32'h1, '0);                   // R6 sub below zero
    for (int s = 0; s < 4; s++) begin                 // R7 each selector
      doOp(3'd1, 0, 8'd4, 32'hF0F0_1234, '0);
      doOp(3'd6, 2'(s), 8'd4, 32'hFF00_4321, '0);
      doOp(3'd0, 0, 8'd4, '0, '0);
    end
    doOp(3'd7, 0, 8'd2, 32'hCAFE, 32'h1234_5678);     // R8 match
    doOp(3'd7, 0, 8'd2, 32'hBEEF, 32'h1234_5678);     // R9 mismatch
    doOp(3'd0, 0, 8'd2, '0, '0);

    for (int n = 0; n < 300; n++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [AW-1:0] a = AW'($urandom_range(0, 15));
      logic [W-1:0] opd = $urandom();
      logic [W-1:0] cmp = $urandom_range(0, 1) ? shadow[a] : $urandom();
      if ($urandom_range(0, 3) == 0) opd = W'($urandom_range(0, 3));
      doOp(op, 2'($urandom_range(0, 3)), a, opd, cmp);
    end

    for (int a = 0; a < 16; a++) doOp(3'd0, 0, AW'(a), '0, '0);   // R2 sweep

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule